// File: doc/BRIEF.md
# Multi-Core Interrupt Distributor

This block collects interrupt requests from three classes of source and hands each core of a multi-core cluster one interrupt line plus the number of the request it should serve. IDs 0 to 15 are raised only by software, through a generate register whose write names the ID and the cores it goes to. IDs 16 to 31 are private: every core has its own banked input, pending bit and enable for each of them, so the same private ID on two cores never interacts. IDs from 32 upward are shared peripheral lines. Each shared ID has a target mask and can be delivered to several cores at once.

Software configures the block through a single-cycle register write port and a combinational read port (word addresses). Each ID has a 4-bit priority and an enable, each core has a global enable, and a request is acknowledged by writing its ID to the clearing register of the serving core. The core count (`NCORE`, default 4, at most 8) and the total ID count (`NID`, default 64, from 33 to 64) are parameters.

Each core has a two-state output machine. In `CORE_QUIET` the line is low and the ID output reads 1023. The transition *raise* goes to `CORE_SIGNAL` when the core has an enabled pending request. In `CORE_SIGNAL` the line is high and the ID output carries the winner, which is updated every cycle. The transition *drop* goes back to `CORE_QUIET` when no request is left.

Top module: `irq_distributor`

## Requirements
- R1: After reset every `irq_o` bit is low, every ID field of `irq_id_o` reads 1023, and the pending read of each core (address 0x30+core) returns 0.
- R2: A write to 0x08 sets the pending state of software ID `wr_data[3:0]`. It targets the cores in `wr_data[8+NCORE-1:8]`, or all cores when `wr_data[16]` is set. Untargeted cores are unaffected, and software IDs never become pending any other way.
- R3: Private ID 16+k on core c becomes pending on a rising edge of `priv_irq[c*16+k]` and is enabled by bit k of address 0x10+c. A line held high does not pend again after a clear, and another core's copy of the same ID is never set.
- R4: Shared ID n (n ≥ 32) follows input `shr_irq[n-32]`. It is delivered to every core whose bit is set in `wr_data[16+NCORE-1:16]` of its configuration word at 0x40+n.
- R5: A pending request is offered to core c only while its per-ID enable is set and the core enable (bit 0 of address 0x00+c) is set. For software and shared IDs the per-ID enable is bit 8 of the word at 0x40+ID; for private IDs it is the banked bit. A blocked request stays pending.
- R6: Among a core's offered requests, the one with the lowest priority value wins. The priority is bits [3:0] of the word at 0x40+ID. On equal priority the lower ID wins.
- R7: A pending request is removed only by writing its ID in `wr_data[9:0]` to address 0x20+c. For IDs below 32 this clears core c's banked copy. For shared IDs it clears the single shared pending bit. Address 0x30+c reads the banked pending bits of core c, and 0x38 reads the shared pending bits (bit n-32 for ID n).
- R8: A shared ID cleared while its input is still high remains pending.
- R9: The line and the ID output are registered and follow a pending change one clock later. When no request is offered, the line is low and the ID output reads 1023.
- R10: When a new pending event and a clear of the same ID and core happen in the same cycle, the ID ends up pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write word address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 8 | Register read word address |
| rd_data | output | 32 | Register read data (combinational) |
| priv_irq | input | NCORE*16 | Private lines, 16 per core, core c at bits [c*16+15:c*16] |
| shr_irq | input | NID-32 | Shared level-sensitive lines for IDs 32 and up |
| irq_o | output | NCORE | Interrupt line per core |
| irq_id_o | output | NCORE*10 | Winning ID per core, core c at bits [c*10+9:c*10] |

## Verification
The hardest situation to reach from the ports is a clear that lands in the same cycle as a new event for the same ID and core. The write port and the input pins are driven independently, so the bench first raises a private line in the very cycle whose edge also takes the clearing write for that ID. It then checks that the core keeps presenting the ID. The level behaviour of shared lines is reached the same way: the shared pending bit is cleared while the input is held high, and only after the input falls does a second clear empty it.

// File: rtl/irqd_pkg.sv
package irqd_pkg;
    localparam int ID_W      = 10;
    localparam int PRIO_W    = 4;
    localparam int SGI_N     = 16;
    localparam int BANK_N    = 32;
    localparam int SHR_BASE  = 32;
    localparam int ADDR_W    = 8;
    localparam int DATA_W    = 32;

    localparam logic [ID_W-1:0] NO_IRQ = '1;

    localparam int A_CORE_EN  = 8'h00;
    localparam int A_SGI      = 8'h08;
    localparam int A_PRIV_EN  = 8'h10;
    localparam int A_CLR      = 8'h20;
    localparam int A_PEND     = 8'h30;
    localparam int A_SHR_PEND = 8'h38;
    localparam int A_CFG      = 8'h40;

    typedef enum logic {
        CORE_QUIET,
        CORE_SIGNAL
    } core_state_e;
endpackage

// File: rtl/irqd_cfg.sv
module irqd_cfg
    import irqd_pkg::*;
#(
    parameter int NCORE = 4,
    parameter int NID   = 64
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [ADDR_W-1:0]                 wr_addr,
    input  logic [DATA_W-1:0]                 wr_data,
    output logic [NCORE-1:0]                  core_en,
    output logic [NCORE-1:0][SGI_N-1:0]       priv_en,
    output logic [NID-1:0][PRIO_W-1:0]        id_prio,
    output logic [NID-1:0]                    id_en,
    output logic [NID-1:0][NCORE-1:0]         id_tgt,
    output logic                              sgi_fire,
    output logic [3:0]                        sgi_id,
    output logic [NCORE-1:0]                  sgi_tgt,
    output logic [NCORE-1:0]                  clr_fire,
    output logic [ID_W-1:0]                   clr_id
);
    logic unused_cfg;
    assign unused_cfg = ^wr_data;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            core_en <= '0;
            priv_en <= '0;
            id_prio <= '0;
            id_en   <= '0;
            id_tgt  <= '0;
        end else if (wr_en) begin
            for (int c = 0; c < NCORE; c++) begin
                if (wr_addr == ADDR_W'(A_CORE_EN + c)) core_en[c] <= wr_data[0];
                if (wr_addr == ADDR_W'(A_PRIV_EN + c)) priv_en[c] <= wr_data[SGI_N-1:0];
            end
            for (int i = 0; i < NID; i++) begin
                if (wr_addr == ADDR_W'(A_CFG + i)) begin
                    id_prio[i] <= wr_data[PRIO_W-1:0];
                    id_en[i]   <= wr_data[8];
                    id_tgt[i]  <= wr_data[16 +: NCORE];
                end
            end
        end
    end

    always_comb begin
        sgi_fire = wr_en && (wr_addr == ADDR_W'(A_SGI));
        sgi_id   = wr_data[3:0];
        sgi_tgt  = wr_data[16] ? '1 : wr_data[8 +: NCORE];
        clr_id   = wr_data[ID_W-1:0];
        for (int c = 0; c < NCORE; c++)
            clr_fire[c] = wr_en && (wr_addr == ADDR_W'(A_CLR + c));
    end
endmodule

// File: rtl/irqd_pend.sv
module irqd_pend
    import irqd_pkg::*;
#(
    parameter int NCORE = 4,
    parameter int NID   = 64,
    localparam int NSHR = NID - SHR_BASE
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NCORE-1:0][SGI_N-1:0]  priv_irq,
    input  logic [NSHR-1:0]              shr_irq,
    input  logic                         sgi_fire,
    input  logic [3:0]                   sgi_id,
    input  logic [NCORE-1:0]             sgi_tgt,
    input  logic [NCORE-1:0]             clr_fire,
    input  logic [ID_W-1:0]              clr_id,
    output logic [NCORE-1:0][BANK_N-1:0] bank_pend_q,
    output logic [NSHR-1:0]              shr_pend_q
);
    logic [NCORE-1:0][SGI_N-1:0]  priv_q;
    logic [NCORE-1:0][BANK_N-1:0] bank_set, bank_clr;
    logic [NSHR-1:0]              shr_clr;

    always_comb begin
        shr_clr = '0;
        for (int c = 0; c < NCORE; c++) begin
            bank_set[c] = {priv_irq[c] & ~priv_q[c], {SGI_N{1'b0}}};
            if (sgi_fire && sgi_tgt[c])
                bank_set[c] = bank_set[c] | (BANK_N'(1) << sgi_id);
            bank_clr[c] = '0;
            if (clr_fire[c] && clr_id < ID_W'(BANK_N))
                bank_clr[c] = BANK_N'(1) << clr_id[4:0];
            if (clr_fire[c] && clr_id >= ID_W'(SHR_BASE) && clr_id < ID_W'(NID))
                shr_clr = shr_clr | (NSHR'(1) << (clr_id - ID_W'(SHR_BASE)));
        end
    end

    // set after clear: a same-cycle event survives the clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            priv_q      <= '0;
            bank_pend_q <= '0;
            shr_pend_q  <= '0;
        end else begin
            priv_q <= priv_irq;
            for (int c = 0; c < NCORE; c++)
                bank_pend_q[c] <= (bank_pend_q[c] & ~bank_clr[c]) | bank_set[c];
            shr_pend_q <= (shr_pend_q & ~shr_clr) | shr_irq;
        end
    end

    for (genvar c = 0; c < NCORE; c++) begin : g_chk
        p_sgi_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (sgi_fire && sgi_tgt[c]) |=>
                (((bank_pend_q[c] >> $past(sgi_id)) & BANK_N'(1)) != '0));
        p_clear_only_by_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (|($past(bank_pend_q[c]) & ~bank_pend_q[c])) |-> $past(clr_fire[c]));
    end

    p_level_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|shr_irq) |=> (($past(shr_irq) & ~shr_pend_q) == '0));
endmodule

// File: rtl/irqd_arb.sv
module irqd_arb
    import irqd_pkg::*;
#(
    parameter int NCORE = 4,
    parameter int NID   = 64,
    localparam int NSHR = NID - SHR_BASE
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NCORE-1:0]             core_en,
    input  logic [NCORE-1:0][SGI_N-1:0]  priv_en,
    input  logic [NID-1:0][PRIO_W-1:0]   id_prio,
    input  logic [NID-1:0]               id_en,
    input  logic [NID-1:0][NCORE-1:0]    id_tgt,
    input  logic [NCORE-1:0][BANK_N-1:0] bank_pend,
    input  logic [NSHR-1:0]              shr_pend,
    output logic [NCORE-1:0]             irq_o,
    output logic [NCORE-1:0][ID_W-1:0]   irq_id_o
);
    logic unused_arb;
    assign unused_arb = ^{id_en[BANK_N-1:SGI_N], id_tgt[BANK_N-1:0]};

    for (genvar c = 0; c < NCORE; c++) begin : g_core
        logic [NID-1:0]    pend_v, en_v;
        logic              best_v;
        logic [PRIO_W-1:0] best_p;
        logic [ID_W-1:0]   best_id, id_d;
        core_state_e       state_q, state_d;

        for (genvar i = 0; i < NID; i++) begin : g_id
            if (i < SGI_N) begin : g_sgi
                assign pend_v[i] = bank_pend[c][i];
                assign en_v[i]   = id_en[i];
            end else if (i < BANK_N) begin : g_priv
                assign pend_v[i] = bank_pend[c][i];
                assign en_v[i]   = priv_en[c][i-SGI_N];
            end else begin : g_shr
                assign pend_v[i] = shr_pend[i-SHR_BASE] & id_tgt[i][c];
                assign en_v[i]   = id_en[i];
            end
        end

        // ascending scan with strict compare: ties go to the lower ID
        always_comb begin
            best_v  = 1'b0;
            best_p  = '1;
            best_id = NO_IRQ;
            for (int i = 0; i < NID; i++) begin
                if (pend_v[i] && en_v[i] && core_en[c] && (!best_v || id_prio[i] < best_p)) begin
                    best_v  = 1'b1;
                    best_p  = id_prio[i];
                    best_id = ID_W'(i);
                end
            end
        end

        always_comb begin
            state_d = state_q;
            unique case (state_q)
                CORE_QUIET:  if (best_v)  state_d = CORE_SIGNAL;
                CORE_SIGNAL: if (!best_v) state_d = CORE_QUIET;
                default:     state_d = CORE_QUIET;
            endcase
            id_d = best_v ? best_id : NO_IRQ;
        end

        always_ff @(posedge clk) begin
            if (!rst_n) state_q <= CORE_QUIET;
            else        state_q <= state_d;
        end

        always_ff @(posedge clk) begin
            if (!rst_n) irq_id_o[c] <= NO_IRQ;
            else        irq_id_o[c] <= id_d;
        end

        assign irq_o[c] = (state_q == CORE_SIGNAL);

        p_core_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
            !core_en[c] |=> !irq_o[c]);
        p_quiet_id_r9: assert property (@(posedge clk) disable iff (!rst_n)
            !irq_o[c] |-> (irq_id_o[c] == NO_IRQ));
        p_signal_id_r9: assert property (@(posedge clk) disable iff (!rst_n)
            irq_o[c] |-> (irq_id_o[c] < ID_W'(NID)));
    end
endmodule

// File: rtl/irq_distributor.sv
module irq_distributor
    import irqd_pkg::*;
#(
    parameter int NCORE = 4,
    parameter int NID   = 64,
    localparam int NSHR = NID - SHR_BASE
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [DATA_W-1:0]       wr_data,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic [DATA_W-1:0]       rd_data,
    input  logic [NCORE*SGI_N-1:0]  priv_irq,
    input  logic [NSHR-1:0]         shr_irq,
    output logic [NCORE-1:0]        irq_o,
    output logic [NCORE*ID_W-1:0]   irq_id_o
);
    logic [NCORE-1:0]             core_en;
    logic [NCORE-1:0][SGI_N-1:0]  priv_en;
    logic [NID-1:0][PRIO_W-1:0]   id_prio;
    logic [NID-1:0]               id_en;
    logic [NID-1:0][NCORE-1:0]    id_tgt;
    logic                         sgi_fire;
    logic [3:0]                   sgi_id;
    logic [NCORE-1:0]             sgi_tgt, clr_fire;
    logic [ID_W-1:0]              clr_id;
    logic [NCORE-1:0][BANK_N-1:0] bank_pend;
    logic [NSHR-1:0]              shr_pend;
    logic [NCORE-1:0][SGI_N-1:0]  priv_v;
    logic [NCORE-1:0][ID_W-1:0]   id_v;

    assign priv_v   = priv_irq;
    assign irq_id_o = id_v;

    irqd_cfg #(.NCORE(NCORE), .NID(NID)) u_cfg (
        .clk, .rst_n, .wr_en, .wr_addr, .wr_data,
        .core_en, .priv_en, .id_prio, .id_en, .id_tgt,
        .sgi_fire, .sgi_id, .sgi_tgt, .clr_fire, .clr_id
    );

    irqd_pend #(.NCORE(NCORE), .NID(NID)) u_pend (
        .clk, .rst_n, .priv_irq(priv_v), .shr_irq,
        .sgi_fire, .sgi_id, .sgi_tgt, .clr_fire, .clr_id,
        .bank_pend_q(bank_pend), .shr_pend_q(shr_pend)
    );

    irqd_arb #(.NCORE(NCORE), .NID(NID)) u_arb (
        .clk, .rst_n, .core_en, .priv_en, .id_prio, .id_en, .id_tgt,
        .bank_pend, .shr_pend, .irq_o, .irq_id_o(id_v)
    );

    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_W'(A_SHR_PEND)) rd_data = DATA_W'(shr_pend);
        for (int c = 0; c < NCORE; c++) begin
            if (rd_addr == ADDR_W'(A_CORE_EN + c)) rd_data = DATA_W'(core_en[c]);
            if (rd_addr == ADDR_W'(A_PRIV_EN + c)) rd_data = DATA_W'(priv_en[c]);
            if (rd_addr == ADDR_W'(A_PEND + c))    rd_data = DATA_W'(bank_pend[c]);
        end
        for (int i = 0; i < NID; i++) begin
            if (rd_addr == ADDR_W'(A_CFG + i)) begin
                rd_data[PRIO_W-1:0]   = id_prio[i];
                rd_data[8]            = id_en[i];
                rd_data[16 +: NCORE]  = id_tgt[i];
            end
        end
    end
endmodule

// File: tb/irq_distributor_tb.sv
module irq_distributor_tb;
    localparam int NCORE = 4;
    localparam int NID   = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [7:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [NCORE*16-1:0] priv_irq = '0;
    logic [NID-33:0]     shr_irq = '0;
    logic [NCORE-1:0]    irq_o;
    logic [NCORE*10-1:0] irq_id_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    irq_distributor #(.NCORE(NCORE), .NID(NID)) u_dut (
        .clk, .rst_n, .wr_en, .wr_addr, .wr_data, .rd_addr, .rd_data,
        .priv_irq, .shr_irq, .irq_o, .irq_id_o
    );

    typedef struct packed {
        logic [7:0]  addr;
        logic [31:0] data;
        logic [2:0]  core;
        logic [9:0]  id;
        logic [3:0]  req;
    } vec_t;

    // each row: write, wait for the registered output, check one core's ID
    localparam vec_t VEC [14] = '{
        '{8'h00, 32'h0000_0001, 3'd0, 10'd1023, 4'd5},  // R5 core0 on, nothing pending
        '{8'h41, 32'h0000_0105, 3'd0, 10'd1023, 4'd2},  // R2 config alone pends nothing
        '{8'h08, 32'h0000_0501, 3'd0, 10'd1,    4'd2},  // R2 ID1 to cores 0 and 2
        '{8'h43, 32'h0000_0105, 3'd2, 10'd1023, 4'd5},  // R5 core2 globally off
        '{8'h02, 32'h0000_0001, 3'd2, 10'd1,    4'd2},  // R2 core2 on
        '{8'h01, 32'h0000_0001, 3'd1, 10'd1023, 4'd2},  // R2 core1 untargeted
        '{8'h08, 32'h0001_0003, 3'd1, 10'd3,    4'd2},  // R2 ID3 to all cores
        '{8'h30, 32'h0000_0000, 3'd0, 10'd1,    4'd6},  // R6 tie at prio 5: lower ID
        '{8'h43, 32'h0000_0102, 3'd0, 10'd3,    4'd6},  // R6 prio 2 beats prio 5
        '{8'h20, 32'h0000_0003, 3'd0, 10'd1,    4'd7},  // R7 clear ID3 on core0
        '{8'h20, 32'h0000_0001, 3'd0, 10'd1023, 4'd7},  // R7 clear ID1 on core0
        '{8'h41, 32'h0000_0005, 3'd2, 10'd3,    4'd6},  // R6 core2 serves ID3
        '{8'h22, 32'h0000_0003, 3'd2, 10'd1023, 4'd5},  // R5 ID1 pending but disabled
        '{8'h41, 32'h0000_0105, 3'd2, 10'd1,    4'd5}   // R5 re-enable: still pending
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        rd_addr = a; #1;
        d = rd_data;
    endtask

    function automatic logic [31:0] id_of(input int c);
        return 32'(irq_id_o[c*10 +: 10]);
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        tick(3);
        rst_n = 1'b1;
        tick(1);

        // R1 reset state
        chk("R1 irq_o", 32'(irq_o), 32'd0);
        for (int c = 0; c < NCORE; c++) chk("R1 id", id_of(c), 32'd1023);
        rd(8'h30, v); chk("R1 pend", v, 32'd0);

        for (int k = 0; k < 14; k++) begin
            wr(VEC[k].addr, VEC[k].data);
            tick(1);
            chk($sformatf("R%0d vec%0d", VEC[k].req, k), id_of(int'(VEC[k].core)), 32'(VEC[k].id));
        end

        // R3 private edge, banked per core
        wr(8'h11, 32'h0000_0010);
        wr(8'h54, 32'h0000_0001);
        priv_irq[16+4] = 1'b1;
        tick(2);
        chk("R3 core1 private", id_of(1), 32'd20);
        rd(8'h30, v); chk("R3 core0 copy untouched", 32'(v[20]), 32'd0);
        rd(8'h31, v); chk("R3 core1 pending", 32'(v[20]), 32'd1);
        wr(8'h21, 32'd20);
        tick(1);
        chk("R3 held line no re-pend", id_of(1), 32'd3);
        priv_irq[16+4] = 1'b0;
        tick(1);

        // R10 rising edge in the same cycle as its clear
        priv_irq[16+4] = 1'b1;
        wr(8'h21, 32'd20);
        tick(1);
        chk("R10 event survives clear", id_of(1), 32'd20);
        priv_irq[16+4] = 1'b0;
        wr(8'h21, 32'd20);
        tick(1);
        chk("R10 later clear", id_of(1), 32'd3);

        // R4 shared delivered to cores 0 and 3
        wr(8'h68, 32'h0009_0100);
        wr(8'h03, 32'h0000_0001);
        shr_irq[8] = 1'b1;
        tick(2);
        chk("R4 core0", id_of(0), 32'd40);
        chk("R4 core3", id_of(3), 32'd40);
        chk("R4 core1 untargeted", id_of(1), 32'd3);

        // R8 clear while the level is high
        wr(8'h20, 32'd40);
        tick(1);
        chk("R8 still served", id_of(0), 32'd40);
        rd(8'h38, v); chk("R8 still pending", 32'(v[8]), 32'd1);
        shr_irq[8] = 1'b0;
        wr(8'h20, 32'd40);
        tick(1);
        chk("R7 shared cleared core0", id_of(0), 32'd1023);
        chk("R7 shared cleared core3", id_of(3), 32'd3);

        // R9 registered output: one clock after pending changes
        wr(8'h08, 32'h0000_0101);
        chk("R9 not yet", 32'(irq_o[0]), 32'd0);
        tick(1);
        chk("R9 line up", 32'(irq_o[0]), 32'd1);
        chk("R9 id", id_of(0), 32'd1);

        // R5 core global enable off
        wr(8'h00, 32'h0000_0000);
        tick(1);
        chk("R5 line low", 32'(irq_o[0]), 32'd0);
        chk("R5 idle id", id_of(0), 32'd1023);

        finish_run();
    end
endmodule